// File: doc/BRIEF.md
# Banked Register Window Decoder

This block places eight banks of byte registers behind one window of eight byte addresses. One offset of the window always holds the bank selector, whatever bank is active, so each bank adds seven registers of its own at the remaining offsets. A host writes the selector to choose a bank and then reads or writes that bank's registers through a plain byte bus with a 3-bit address, write and read strobes, and separate write and read data.

Banks 0 to 3 form a shared group that is usable in both the serial-port mode and the infrared mode. Banks 4 to 7 hold infrared-only configuration; while the block is in serial-port mode they are fenced off. The decoder produces one write enable per banked register and a registered read-data multiplexer. Simple byte storage behind the write enables stands in for the real registers, so that the decode can be checked end to end.

Top module: `bank_window_decode`

## Requirements
- R1: After reset the selected bank is 0, `rdata_o` is 0x00 and every banked register holds 0x00.
- R2: Offset 3 is the bank selector in every bank and in both modes. A write there stores `wdata_i[2:0]` as the bank and raises no banked write enable. A read there returns the bank in bits [2:0], with bits [7:3] zero.
- R3: A selector write takes effect from the next access on; the access in the following cycle uses the new bank.
- R4: Offsets 0, 1 and 2 map to slots 0 to 2, and offsets 4 to 7 map to slots 3 to 6. A write with `wr_i` high raises only `wr_en_o[bank*7+slot]`, in the same cycle.
- R5: With `wr_i` low no write enable is raised, and at most one write enable is ever high.
- R6: `rdata_o` loads on the clock edge that samples `rd_i` high and holds its value while `rd_i` is low.
- R7: The same offset in different banks reaches separate storage.
- R8: With `ir_mode_i` low (serial-port mode) and bank 4 to 7 selected, writes to offsets other than 3 are dropped and reads of them return 0x00. The stored contents stay intact and reappear in infrared mode.
- R9: With `ir_mode_i` high, banks 4 to 7 are fully readable and writable.
- R10: Banks 0 to 3 are readable and writable in serial-port mode.
- R11: A read and a write in the same cycle to the same register return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_mode_i | input | 1 | 1 selects infrared mode, 0 selects serial-port mode |
| addr_i | input | 3 | Window offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| wr_en_o | output | 56 | Write enable per banked register, index bank*7+slot |

## Verification
The assertions assume that the bank selector only holds values below the bank count, that `ir_mode_i` and `addr_i` are stable around the sampling edge, and that the bus issues at most one address per cycle. The stimulus drives every input at the falling edge and keeps it for one full cycle. It writes the selector only with values whose low three bits name a real bank, and it changes mode only between accesses. Overlapping read and write strobes are used only for the same-register case.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;
  localparam int WIN_ADDR_W   = 3;
  localparam int BYTE_W       = 8;
  localparam int BANK_COUNT   = 8;
  localparam int SEL_OFFSET   = 3;
  localparam int SHARED_BANKS = 4;

  function automatic int slots_per_bank(input int addr_w);
    return (1 << addr_w) - 1;
  endfunction
endpackage

// File: rtl/bank_select_reg.sv
module bank_select_reg #(
  parameter int ADDR_W     = 3,
  parameter int BANK_W     = 3,
  parameter int SEL_OFFSET = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_wdata_i,
  output logic [BANK_W-1:0] bank_o
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_OFFSET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        bank_o <= '0;
    else if (wr_i && addr_i == SEL_ADDR) bank_o <= bank_wdata_i;
  end
endmodule

// File: rtl/window_access_decode.sv
module window_access_decode #(
  parameter int ADDR_W       = 3,
  parameter int BANK_W       = 3,
  parameter int SEL_OFFSET   = 3,
  parameter int SHARED_BANKS = 4,
  parameter int NUM_REGS     = 56,
  parameter int IDX_W        = 6
) (
  input  logic                ir_mode_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BANK_W-1:0]   bank_i,
  output logic                sel_hit_o,
  output logic                blocked_o,
  output logic [IDX_W-1:0]    reg_idx_o,
  output logic [NUM_REGS-1:0] wr_en_o
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_OFFSET);
  localparam logic [IDX_W-1:0]  SLOTS    = IDX_W'(bank_window_pkg::slots_per_bank(ADDR_W));
  localparam logic [BANK_W:0]   SHARED_L = (BANK_W+1)'(SHARED_BANKS);

  logic [ADDR_W-1:0] slot;

  always_comb begin
    sel_hit_o = (addr_i == SEL_ADDR);
    // offsets above the selector close the gap it leaves
    slot      = (addr_i > SEL_ADDR) ? addr_i - 1'b1 : addr_i;
    reg_idx_o = IDX_W'(bank_i) * SLOTS + IDX_W'(slot);
    blocked_o = !ir_mode_i && ({1'b0, bank_i} >= SHARED_L);
    wr_en_o   = '0;
    if (wr_i && !sel_hit_o && !blocked_o) wr_en_o[reg_idx_o] = 1'b1;
  end
endmodule

// File: rtl/banked_byte_store.sv
module banked_byte_store #(
  parameter int NUM_REGS = 56,
  parameter int DATA_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_REGS-1:0]        wr_en_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         regs_o[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en_i[g]) regs_o[g*DATA_W +: DATA_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/window_read_port.sv
module window_read_port #(
  parameter int NUM_REGS = 56,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 3,
  parameter int IDX_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic                       sel_hit_i,
  input  logic                       blocked_i,
  input  logic [IDX_W-1:0]           reg_idx_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (sel_hit_i)      rd_mux = DATA_W'(bank_i);
    else if (blocked_i) rd_mux = '0;
    else                rd_mux = regs_i[reg_idx_i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/bank_window_decode.sv
module bank_window_decode #(
  parameter int ADDR_W       = bank_window_pkg::WIN_ADDR_W,
  parameter int DATA_W       = bank_window_pkg::BYTE_W,
  parameter int NUM_BANKS    = bank_window_pkg::BANK_COUNT,
  parameter int SEL_OFFSET   = bank_window_pkg::SEL_OFFSET,
  parameter int SHARED_BANKS = bank_window_pkg::SHARED_BANKS,
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int NUM_REGS    = NUM_BANKS * bank_window_pkg::slots_per_bank(ADDR_W),
  localparam int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ir_mode_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_REGS-1:0] wr_en_o
);
  logic [BANK_W-1:0]          bank_q;
  logic                       sel_hit, blocked;
  logic [IDX_W-1:0]           reg_idx;
  logic [NUM_REGS*DATA_W-1:0] regs;

  bank_select_reg #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SEL_OFFSET(SEL_OFFSET)
  ) i_bank_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .bank_wdata_i(wdata_i[BANK_W-1:0]), .bank_o(bank_q)
  );

  window_access_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .SEL_OFFSET(SEL_OFFSET),
    .SHARED_BANKS(SHARED_BANKS), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) i_decode (
    .ir_mode_i(ir_mode_i), .wr_i(wr_i), .addr_i(addr_i), .bank_i(bank_q),
    .sel_hit_o(sel_hit), .blocked_o(blocked), .reg_idx_o(reg_idx), .wr_en_o(wr_en_o)
  );

  banked_byte_store #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) i_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_o), .wdata_i(wdata_i), .regs_o(regs)
  );

  window_read_port #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) i_read (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .sel_hit_i(sel_hit),
    .blocked_i(blocked), .reg_idx_i(reg_idx), .bank_i(bank_q), .regs_i(regs),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bank_window_checker.sv
module bank_window_checker #(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 3,
  parameter int NUM_REGS   = 56,
  parameter int SEL_OFFSET = 3,
  parameter int SHARED     = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ir_mode_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [BANK_W-1:0]   sel_wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [NUM_REGS-1:0] wr_en_o,
  input logic [BANK_W-1:0]   bank_q
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_OFFSET);
  localparam logic [BANK_W:0]   SHR      = (BANK_W+1)'(SHARED);

  logic sel_wr, high_fenced;
  assign sel_wr      = wr_i && (addr_i == SEL_ADDR);
  assign high_fenced = !ir_mode_i && ({1'b0, bank_q} >= SHR);

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o)); // R5
  AST_WE_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> (wr_en_o == '0)); // R5
  AST_SEL_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |-> (wr_en_o == '0)); // R2
  AST_FENCED_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_fenced |-> (wr_en_o == '0)); // R8
  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> (bank_q == $past(sel_wdata_i))); // R3
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(bank_q)); // R2
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R6
  AST_FENCED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && high_fenced && addr_i != SEL_ADDR) |=> (rdata_o == '0)); // R8
  AST_SEL_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == SEL_ADDR) |=> (rdata_o == DATA_W'($past(bank_q)))); // R2
endmodule

bind bank_window_decode bank_window_checker i_bank_window_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_mode_i(ir_mode_i), .addr_i(addr_i),
  .wr_i(wr_i), .rd_i(rd_i), .sel_wdata_i(wdata_i[2:0]), .rdata_o(rdata_o),
  .wr_en_o(wr_en_o), .bank_q(bank_q)
);

// File: tb/test_bank_window_decode.sv
module test_bank_window_decode;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 56;

  logic            clk = 1'b0, rst_n = 1'b0, ir_mode = 1'b1;
  logic [2:0]      addr = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic [NREG-1:0] wr_en;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mem_m [NREG];
  int         bank_m = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_seen = 1'b0;

  bank_window_decode i_bank_window_decode (
    .clk_i(clk), .rst_ni(rst_n), .ir_mode_i(ir_mode), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .wr_en_o(wr_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int idx_of(int b, int a);
    return b * 7 + ((a > 3) ? a - 1 : a);
  endfunction

  function automatic bit fenced();
    return !ir_mode && bank_m >= 4;
  endfunction

  // driver: one access per cycle, expected read data goes to the scoreboard
  task automatic access(bit w, bit r, int a, logic [7:0] d, string tag);
    logic [NREG-1:0] exp_we;
    @(negedge clk);
    wr = w; rd = r; addr = 3'(a); wdata = d;
    #1;
    exp_we = '0;
    if (w && a != 3 && !fenced()) exp_we[idx_of(bank_m, a)] = 1'b1;
    chk({tag, " wr_en"}, 64'(wr_en), 64'(exp_we));
    if (r) begin
      if (a == 3)        exp_q.push_back(8'(bank_m));
      else if (fenced()) exp_q.push_back(8'h00);
      else               exp_q.push_back(mem_m[idx_of(bank_m, a)]);
      tag_q.push_back(tag);
    end
    if (w) begin
      if (a == 3)           bank_m = int'(d[2:0]);
      else if (!fenced())   mem_m[idx_of(bank_m, a)] = d;
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
    end
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; ir_mode = m;
  endtask

  // monitor: compare each registered read against the scoreboard
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rst_n && rd_seen) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 64'd1, 64'd0);
      else chk(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata after reset", 64'(rdata), 64'h0);
    access(0, 1, 3, 8'h00, "R1 bank after reset");
    access(0, 1, 0, 8'h00, "R1 storage after reset");

    for (int b = 0; b < 8; b++) begin
      access(1, 0, 3, 8'(b), "R2 select");
      for (int a = 0; a < 8; a++)
        if (a != 3) access(1, 0, a, 8'(b * 16 + a) ^ 8'hA5, b >= 4 ? "R9 ir write" : "R4 write");
    end
    for (int b = 0; b < 8; b++) begin
      access(1, 0, 3, 8'(b), "R2 select");
      for (int a = 0; a < 8; a++)
        if (a != 3) access(0, 1, a, 8'h00, b >= 4 ? "R9 ir read" : "R7 read");
    end

    access(1, 0, 3, 8'hFD, "R2 select upper bits");
    access(0, 1, 3, 8'h00, "R2 selector readback");
    access(1, 0, 3, 8'h01, "R3 select");
    access(0, 1, 0, 8'h00, "R3 next access new bank");
    access(1, 1, 2, 8'h3C, "R11 same cycle old value");
    access(0, 1, 2, 8'h00, "R11 new value");
    idle(3);
    chk("R6 rdata hold", 64'(rdata), 64'h3C);
    access(0, 1, 1, 8'h00, "R5 read only");

    set_mode(0);
    access(1, 0, 3, 8'h06, "R2 select in uart");
    access(0, 1, 3, 8'h00, "R2 selector in uart");
    access(1, 0, 0, 8'h77, "R8 fenced write");
    access(0, 1, 0, 8'h00, "R8 fenced read");
    access(0, 1, 7, 8'h00, "R8 fenced read top");
    access(1, 0, 3, 8'h02, "R10 select");
    access(1, 0, 4, 8'h11, "R10 uart write");
    access(0, 1, 4, 8'h00, "R10 uart read");
    set_mode(1);
    access(1, 0, 3, 8'h06, "R8 select");
    access(0, 1, 0, 8'h00, "R8 contents kept");
    idle(4);
    chk("scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule